// File: doc/BRIEF.md
# Chainable SPI Target Shift Register

This block is the target side of a synchronous serial link. It is built around a shift register whose length is a parameter, and odd lengths work. A host drives an active-low select, a serial clock and serial data into the block. The block returns serial data from the top bit of its register, together with an output-enable that stands in for the pad tristate.

All inputs from the serial side are first brought into the system clock through a two-stage synchronizer. Edges of the serial clock are then detected in the system domain, so the system clock must run several times faster than the serial clock. Clock polarity and phase are static inputs, which gives the four usual link modes.

Each group of `WIDTH` sampling edges produces a parallel word and a one-cycle strobe. A parallel transmit word can be staged at any time and is loaded when the next frame starts. Several copies can be chained, each data output feeding the next copy's data input, all under one select. The chain then behaves as a single longer register.

Top module: `spiChainSlave`

## Requirements
- R1: While and after reset, with no frame run, `sdoEn` is 0, `rxValid` is 0 and `rxWord` is all zeros.
- R2: `sdoEn` is 1 exactly while `csN` is low, delayed by the two-stage synchronizer. Otherwise it is 0.
- R3: Received bits enter MSB first. On the `WIDTH`-th sampling edge of a frame, `rxWord` takes the last `WIDTH` received bits, the first one in bit `WIDTH-1`. `rxValid` pulses high for exactly one system clock, and `rxWord` changes at no other time.
- R4: A `txLoad` pulse captures `txData`. On the falling edge of `csN` the captured word is copied into the register. `sdo` always shows the register's top bit, so the host receives the word MSB first.
- R5: `cpol` sets the idle level of `sclk`. With `cpha`=0, data is sampled on the leading edge of each clock pulse (the edge away from idle) and the register shifts on the trailing edge. With `cpha`=1 the two edges swap roles. All four modes (0: 0/0, 1: 0/1, 2: 1/0, 3: 1/1) transfer data correctly.
- R6: With `cpha`=0, the MSB of the loaded word is on `sdo`, with `sdoEn` high, before the first `sclk` edge of the frame.
- R7: If no `txLoad` pulse arrives between two frames, the second frame sends the same word again.
- R8: Raising `csN` before the `WIDTH`-th sampling edge aborts the frame. No `rxValid` pulse follows, `rxWord` keeps its value, and the next frame starts counting bits from zero.
- R9: `sclk` edges while `csN` is high have no effect: no `rxValid`, and `rxWord` and `sdo` stay unchanged.
- R10: In a chain, `sdo` carries the bit that falls out of the register. Two 9-bit copies under one select behave as one 18-bit register, and each copy pulses `rxValid` after every `WIDTH` sampling edges within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level (static) |
| cpha | input | 1 | Selects which clock edge samples (static) |
| csN | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, top bit of the register |
| sdoEn | output | 1 | Output-enable for `sdo`, high while selected |
| txData | input | WIDTH | Word to send in the next frame |
| txLoad | input | 1 | One-cycle strobe that captures `txData` |
| rxWord | output | WIDTH | Last complete received word |
| rxValid | output | 1 | One-cycle strobe when `rxWord` updates |

## Verification
Full 9-bit frames are run in all four clock modes with asymmetric patterns such as 0x1A5 and 0x05A, so a bit-order or edge-choice error shows up as a wrong word. Two back-to-back frames without a reload separate a correct resend from a cleared or shifted-out register. A 5-bit aborted frame followed by a full frame shows whether the bit counter really resets. Serial clock toggling while the block is deselected shows whether idle edges are ignored. An 18-bit frame through two chained copies distinguishes passing the falling-out bit from echoing the input, and it checks that both copies end up with the correct halves.

// File: rtl/spiChainPkg.sv
package spiChainPkg;
  typedef struct packed {
    logic load;     // copy staged word into register (select fell)
    logic sample;   // capture serial input bit
    logic shift;    // move captured bit into register
    logic finish;   // last sampling edge of a word
    logic dataBit;  // synchronized serial input
  } spiStrobes_t;
endpackage

// File: rtl/spiChainCtrl.sv
module spiChainCtrl
  import spiChainPkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        selected,
  output spiStrobes_t strobes
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic csMeta, csSync, csPrev;
  logic clkMeta, clkSync, clkPrev;
  logic dinMeta, dinSync;
  logic [CNT_W-1:0] bitCnt;
  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csMeta  <= 1'b1;
      csSync  <= 1'b1;
      csPrev  <= 1'b1;
      clkMeta <= 1'b0;
      clkSync <= 1'b0;
      clkPrev <= 1'b0;
      dinMeta <= 1'b0;
      dinSync <= 1'b0;
    end else begin
      csMeta  <= csN;
      csSync  <= csMeta;
      csPrev  <= csSync;
      clkMeta <= sclk;
      clkSync <= clkMeta;
      clkPrev <= clkSync;
      dinMeta <= sdi;
      dinSync <= dinMeta;
    end
  end

  logic csFall, normNow, normPrev, leadEdge, trailEdge, sampleEdge, changeEdge;

  always_comb begin
    selected   = ~csSync;
    csFall     = csPrev & ~csSync;
    normNow    = clkSync ^ cpol;
    normPrev   = clkPrev ^ cpol;
    leadEdge   = selected & normNow & ~normPrev;
    trailEdge  = selected & ~normNow & normPrev;
    sampleEdge = cpha ? trailEdge : leadEdge;
    changeEdge = cpha ? leadEdge : trailEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      pending <= 1'b0;
    end else if (!selected) begin
      bitCnt  <= '0;
      pending <= 1'b0;
    end else if (sampleEdge) begin
      pending <= 1'b1;
      bitCnt  <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
    end else if (changeEdge) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    strobes.load    = csFall;
    strobes.sample  = sampleEdge;
    strobes.shift   = changeEdge & pending;
    strobes.finish  = sampleEdge & (bitCnt == LAST);
    strobes.dataBit = dinSync;
  end
endmodule

// File: rtl/spiChainData.sv
module spiChainData
  import spiChainPkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiStrobes_t      strobes,
  input  logic [WIDTH-1:0] txData,
  input  logic             txLoad,
  output logic             sdo,
  output logic [WIDTH-1:0] rxWord,
  output logic             rxValid
);
  logic [WIDTH-1:0] txHold;
  logic [WIDTH-1:0] shiftReg;
  logic             heldBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
    end else if (txLoad) begin
      txHold <= txData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      heldBit  <= 1'b0;
    end else begin
      if (strobes.sample) begin
        heldBit <= strobes.dataBit;
      end
      if (strobes.load) begin
        shiftReg <= txHold;
      end else if (strobes.shift) begin
        shiftReg <= {shiftReg[WIDTH-2:0], heldBit};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobes.finish;
      if (strobes.finish) begin
        rxWord <= {shiftReg[WIDTH-2:0], strobes.dataBit};
      end
    end
  end

  assign sdo = shiftReg[WIDTH-1];
endmodule

// File: rtl/spiChainSlave.sv
module spiChainSlave
  import spiChainPkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdoEn,
  input  logic [WIDTH-1:0] txData,
  input  logic             txLoad,
  output logic [WIDTH-1:0] rxWord,
  output logic             rxValid
);
  spiStrobes_t strobes;
  logic        selected;

  spiChainCtrl #(.WIDTH(WIDTH)) ctrl (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha),
    .csN(csN), .sclk(sclk), .sdi(sdi),
    .selected(selected), .strobes(strobes)
  );

  spiChainData #(.WIDTH(WIDTH)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txData(txData), .txLoad(txLoad),
    .sdo(sdo), .rxWord(rxWord), .rxValid(rxValid)
  );

  assign sdoEn = selected;
endmodule

// File: rtl/spiChainSlaveChecker.sv
module spiChainSlaveChecker #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sdo,
  input logic             sdoEn,
  input logic [WIDTH-1:0] rxWord,
  input logic             rxValid
);
  logic [1:0] sinceReset;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end
  assign warm = (sinceReset == 2'd3);

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    warm && rxValid |=> !rxValid);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    warm && !rxValid |-> $stable(rxWord));

  assert_enable_follows_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (sdoEn == !$past(csN, 2)));

  assert_idle_sdo_R9: assert property (@(posedge clk) disable iff (!rstN)
    warm && !sdoEn && !$past(sdoEn) |-> $stable(sdo));

  assert_valid_inframe_R8: assert property (@(posedge clk) disable iff (!rstN)
    warm && rxValid |-> $past(sdoEn));
endmodule

bind spiChainSlave spiChainSlaveChecker #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdo(sdo), .sdoEn(sdoEn),
  .rxWord(rxWord), .rxValid(rxValid)
);

// File: tb/spiChainSlave_test.sv
module spiChainSlave_test;
  localparam int W = 9;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] txA = '0, txB = '0;
  logic loadA = 1'b0, loadB = 1'b0;
  logic sdoA, enA, sdoB, enB;
  logic [W-1:0] rxA, rxB;
  logic validA, validB;
  logic chainMode = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [W-1:0] expQ[$];
  logic firstBit, firstEn;

  always #10 clk = ~clk;

  spiChainSlave #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .csN(csN), .sclk(sclk),
    .sdi(sdi), .sdo(sdoA), .sdoEn(enA), .txData(txA), .txLoad(loadA),
    .rxWord(rxA), .rxValid(validA)
  );

  spiChainSlave #(.WIDTH(W)) tail (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .csN(csN), .sclk(sclk),
    .sdi(sdoA), .sdo(sdoB), .sdoEn(enB), .txData(txB), .txLoad(loadB),
    .rxWord(rxB), .rxValid(validB)
  );

  assign miso = chainMode ? sdoB : sdoA;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int k);
    repeat (k) @(negedge clk);
  endtask

  // scoreboard monitor on the received-word strobe
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (validA) begin
        logic [W-1:0] e;
        check(!prevValid, "R3 pulse width", 32'(prevValid), 32'd0);
        if (expQ.size() == 0) begin
          check(1'b0, "R8/R9 unexpected rxValid", 32'(rxA), 32'd0);
        end else begin
          e = expQ.pop_front();
          check(rxA == e, "R3 rxWord", 32'(rxA), 32'(e));
        end
      end
      prevValid <= validA;
    end
  end

  task automatic setMode(input logic p, input logic h);
    cpol = p; cpha = h; sclk = p;
    waitClk(6);
  endtask

  task automatic loadWord(input logic [W-1:0] a, input logic [W-1:0] b);
    txA = a; txB = b; loadA = 1'b1; loadB = 1'b1;
    waitClk(1);
    loadA = 1'b0; loadB = 1'b0;
  endtask

  task automatic frame(input int n, input logic [31:0] mo, output logic [31:0] mi);
    mi = '0;
    csN = 1'b0;
    if (!cpha) sdi = mo[n-1];
    waitClk(H);
    firstBit = miso; firstEn = enA;
    for (int i = 0; i < n; i++) begin
      if (cpha) sdi = mo[n-1-i];
      else mi = {mi[30:0], miso};
      sclk = ~cpol;
      waitClk(H);
      if (cpha) mi = {mi[30:0], miso};
      sclk = cpol;
      if (!cpha && i < n-1) sdi = mo[n-2-i];
      waitClk(H);
    end
    csN = 1'b1;
    waitClk(2*H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [W-1:0] keep;
    logic sdoKeep;
    waitClk(5);
    // R1 reset state
    check(enA == 0 && validA == 0, "R1 reset outputs", {enA, validA}, 0);
    check(rxA == '0, "R1 reset rxWord", 32'(rxA), 0);
    rstN = 1'b1;
    waitClk(4);
    check(enA == 0 && validA == 0 && rxA == '0, "R1 after reset", 32'(rxA), 0);

    // R5 all four modes, R4 transmit MSB first
    for (int m = 0; m < 4; m++) begin
      logic [W-1:0] tw, mw;
      setMode(m[1], m[0]);
      tw = 9'h1A5 ^ 9'(m * 37);
      mw = 9'h05A ^ 9'(m * 91);
      loadWord(tw, 9'h000);
      expQ.push_back(mw);
      frame(W, 32'(mw), got);
      check(got[W-1:0] == tw, $sformatf("R4 R5 mode %0d miso", m), got, 32'(tw));
      check(firstEn == 1'b1, "R2 sdoEn during frame", 32'(firstEn), 1);
      if (!cpha) check(firstBit == tw[W-1], "R6 first bit before edge",
                       32'(firstBit), 32'(tw[W-1]));
      check(enA == 1'b0, "R2 sdoEn after frame", 32'(enA), 0);
    end

    // R7 resend without reload
    setMode(1'b0, 1'b0);
    loadWord(9'h133, 9'h000);
    expQ.push_back(9'h0F0);
    frame(W, 32'h0F0, got);
    check(got[W-1:0] == 9'h133, "R4 first send", got, 32'h133);
    expQ.push_back(9'h10F);
    frame(W, 32'h10F, got);
    check(got[W-1:0] == 9'h133, "R7 resend", got, 32'h133);

    // R8 abort mid-frame
    keep = rxA;
    frame(5, 32'h15, got);
    check(rxA == keep, "R8 rxWord kept after abort", 32'(rxA), 32'(keep));
    check(expQ.size() == 0, "R8 no pending word", expQ.size(), 0);
    expQ.push_back(9'h0C3);
    frame(W, 32'h0C3, got);
    check(got[W-1:0] == 9'h133, "R8 realigned miso", got, 32'h133);
    check(rxA == 9'h0C3, "R8 realigned rxWord", 32'(rxA), 32'h0C3);

    // R9 deselected clock edges ignored
    keep = rxA;
    sdoKeep = sdoA;
    for (int i = 0; i < 20; i++) begin
      sdi = i[0] ^ i[2];
      sclk = ~sclk;
      waitClk(H);
    end
    sclk = cpol;
    waitClk(H);
    check(rxA == keep, "R9 rxWord unchanged", 32'(rxA), 32'(keep));
    check(sdoA == sdoKeep && enA == 0, "R9 sdo unchanged", {enA, sdoA}, {1'b0, sdoKeep});
    expQ.push_back(9'h1E1);
    frame(W, 32'h1E1, got);
    check(rxA == 9'h1E1, "R9 next frame intact", 32'(rxA), 32'h1E1);

    // R10 two chained copies as one 18-bit register, mode 0 and mode 3
    chainMode = 1'b1;
    for (int m = 0; m < 4; m += 3) begin
      logic [17:0] s;
      setMode(m[1], m[0]);
      s = 18'h2B4C7 ^ 18'(m * 4099);
      loadWord(9'h0A9, 9'h156);
      expQ.push_back(s[17:9]);
      expQ.push_back(s[8:0]);
      frame(18, 32'(s), got);
      check(got[17:0] == {9'h156, 9'h0A9}, "R10 chain miso", got, {14'd0, 9'h156, 9'h0A9});
      check(rxB == s[17:9], "R10 tail word", 32'(rxB), 32'(s[17:9]));
      check(rxA == s[8:0], "R10 head word", 32'(rxA), 32'(s[8:0]));
    end
    chainMode = 1'b0;

    waitClk(10);
    check(expQ.size() == 0, "R3 all words seen", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule